// File: doc/BRIEF.md
# LCD Backplane and Segment Phase Generator

This block makes the square-wave common (backplane) drive for a static liquid-crystal display. It also makes one segment line per display element, so that a dark segment is the inverted backplane and a blank segment is an exact copy of it. The average voltage across every segment is zero, and the on or off state depends only on the relative phase of the two lines.

The backplane has two sources, chosen by a mode input. In oscillator mode, rising edges on the oscillator input advance an 8-stage binary divider, and the top divider bit becomes the backplane. One backplane period is therefore 256 input periods, with equal high and low halves. In driven mode the divider is held cleared and bypassed, so the backplane follows the input level directly. This lets several devices in a chain share one common phase: the first device divides, and every later device is driven from the first device's backplane. The oscillator input is asynchronous to `clk` and passes through a synchronizer first.

The 32 segment bits come from latches outside this block. While reset is asserted, and in the first cycle after it, the segment bits are masked. This blanks the display until real data is in force.

Top module: `lcd_phase_gen`

## Requirements
- R1: While `rst_n` is low, `bp_o` is 0 and every `seg_o` bit equals `bp_o` (display blank), whatever `seg_bits_i` holds.
- R2: In oscillator mode (`mode_drv_i` = 0), `bp_o` is 1 exactly when the number of `osc_i` rising edges seen since reset or since leaving driven mode, taken modulo 256, is 128 or more. Falling edges and steady levels do not advance it.
- R3: In oscillator mode the backplane has a 50% duty cycle: across any 256 consecutive `osc_i` rising edges, `bp_o` is high after exactly 128 of them.
- R4: In driven mode (`mode_drv_i` = 1), `bp_o` equals `osc_i` delayed by exactly 3 `clk` rising edges (two synchronizer stages plus the backplane register).
- R5: The divider is held at zero while in driven mode, so on return to oscillator mode the count restarts from zero. No edges seen before or during driven mode carry over.
- R6: Outside reset, a segment bit of 0 makes that `seg_o` bit equal to `bp_o` (segment off).
- R7: Outside reset, a segment bit of 1 makes that `seg_o` bit equal to the inverse of `bp_o` (segment on).
- R8: A change on `seg_bits_i` reaches `seg_o` within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_i | input | 1 | Oscillator or external backplane input, asynchronous |
| mode_drv_i | input | 1 | 0 = oscillator mode (divide by 256), 1 = driven mode (bypass) |
| seg_bits_i | input | 32 | Latched segment data, 1 = segment on |
| bp_o | output | 1 | Backplane output |
| seg_o | output | 32 | Segment outputs, in phase or anti-phase with `bp_o` |

## Verification
Two functions can act in the same cycle: a backplane transition and a change in segment data. Both land on `seg_o`. The bench provokes this by walking a table of segment patterns with the backplane held high and then low, and by changing `seg_bits_i` between clock edges. Each segment is judged bit by bit against the in-phase or anti-phase rule for the backplane level at that moment. A second overlap is a mode change while the divider holds a partial count. It is provoked by leaving oscillator mode part way through a half period, and judged by where the next backplane rise falls after the return.

// File: rtl/lcd_phase_pkg.sv
package lcd_phase_pkg;

    localparam int DEF_SEG_COUNT   = 32;
    localparam int DEF_DIV_BITS    = 8;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic {
        BP_SRC_DIVIDED = 1'b0,
        BP_SRC_DRIVEN  = 1'b1
    } bp_src_e;

endpackage

// File: rtl/lcd_osc_sync.sv
module lcd_osc_sync #(
    parameter int STAGES = lcd_phase_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_i,
    output logic osc_lvl_o,
    output logic osc_rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = (st_q.chain << 1) | STAGES'(osc_i);
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign osc_lvl_o  = st_q.chain[STAGES-1];
    assign osc_rise_o = st_q.chain[STAGES-1] & ~st_q.prev;

endmodule

// File: rtl/lcd_bp_divider.sv
module lcd_bp_divider #(
    parameter int DIV_BITS = lcd_phase_pkg::DEF_DIV_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_drv_i,
    input  logic                osc_lvl_i,
    input  logic                osc_rise_i,
    output logic                bp_o,
    output logic [DIV_BITS-1:0] div_cnt_o
);

    import lcd_phase_pkg::*;

    localparam int MSB = DIV_BITS - 1;

    typedef struct packed {
        logic [DIV_BITS-1:0] cnt;
        logic                bp;
    } div_state_t;

    div_state_t st_d, st_q;
    bp_src_e    src;

    assign src = bp_src_e'(mode_drv_i);

    always_comb begin
        st_d = st_q;
        if (src == BP_SRC_DRIVEN) begin
            st_d.cnt = '0;
            st_d.bp  = osc_lvl_i;
        end else begin
            if (osc_rise_i) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            st_d.bp = st_q.cnt[MSB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bp_o      = st_q.bp;
    assign div_cnt_o = st_q.cnt;

endmodule

// File: rtl/lcd_seg_phase.sv
module lcd_seg_phase #(
    parameter int SEG_COUNT = lcd_phase_pkg::DEF_SEG_COUNT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bp_i,
    input  logic [SEG_COUNT-1:0] seg_bits_i,
    output logic [SEG_COUNT-1:0] seg_o
);

    typedef struct packed {
        logic run;
    } seg_state_t;

    seg_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.run = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
        assign seg_o[g] = bp_i ^ (seg_bits_i[g] & st_q.run);
    end

endmodule

// File: rtl/lcd_phase_gen.sv
module lcd_phase_gen #(
    parameter int SEG_COUNT   = lcd_phase_pkg::DEF_SEG_COUNT,
    parameter int DIV_BITS    = lcd_phase_pkg::DEF_DIV_BITS,
    parameter int SYNC_STAGES = lcd_phase_pkg::DEF_SYNC_STAGES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 osc_i,
    input  logic                 mode_drv_i,
    input  logic [SEG_COUNT-1:0] seg_bits_i,
    output logic                 bp_o,
    output logic [SEG_COUNT-1:0] seg_o
);

    logic                osc_lvl;
    logic                osc_rise;
    logic [DIV_BITS-1:0] div_cnt;

    lcd_osc_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_i      (osc_i),
        .osc_lvl_o  (osc_lvl),
        .osc_rise_o (osc_rise)
    );

    lcd_bp_divider #(
        .DIV_BITS (DIV_BITS)
    ) div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_drv_i (mode_drv_i),
        .osc_lvl_i  (osc_lvl),
        .osc_rise_i (osc_rise),
        .bp_o       (bp_o),
        .div_cnt_o  (div_cnt)
    );

    lcd_seg_phase #(
        .SEG_COUNT (SEG_COUNT)
    ) seg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bp_i       (bp_o),
        .seg_bits_i (seg_bits_i),
        .seg_o      (seg_o)
    );

endmodule

// File: rtl/lcd_phase_gen_chk.sv
module lcd_phase_gen_chk #(
    parameter int SEG_COUNT = 32,
    parameter int DIV_BITS  = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mode_drv_i,
    input logic [SEG_COUNT-1:0] seg_bits_i,
    input logic                 bp_o,
    input logic [SEG_COUNT-1:0] seg_o,
    input logic                 osc_lvl,
    input logic                 osc_rise,
    input logic [DIV_BITS-1:0]  div_cnt
);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_blank_R1: assert (bp_o == 1'b0 && seg_o == '0)
                else $error("R1: backplane or segments active in reset");
        end
    end

    assert_div_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mode_drv_i) |->
            ((div_cnt == DIV_BITS'($past(div_cnt) + 1'b1)) == $past(osc_rise)))
        else $error("R2: divider step does not match detected rising edge");

    assert_bp_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mode_drv_i) |-> (bp_o == $past(div_cnt[DIV_BITS-1])))
        else $error("R3: backplane not taken from divider top bit");

    assert_driven_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_drv_i) |-> (bp_o == $past(osc_lvl)))
        else $error("R4: backplane does not follow synchronized input");

    assert_div_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_drv_i) |-> (div_cnt == '0))
        else $error("R5: divider not held clear in driven mode");

    assert_seg_phase_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((seg_o ^ {SEG_COUNT{bp_o}}) == seg_bits_i))
        else $error("R6/R7: segment phase disagrees with segment data");

endmodule

bind lcd_phase_gen lcd_phase_gen_chk #(
    .SEG_COUNT (SEG_COUNT),
    .DIV_BITS  (DIV_BITS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_drv_i (mode_drv_i),
    .seg_bits_i (seg_bits_i),
    .bp_o       (bp_o),
    .seg_o      (seg_o),
    .osc_lvl    (osc_lvl),
    .osc_rise   (osc_rise),
    .div_cnt    (div_cnt)
);

// File: tb/lcd_phase_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_phase_gen_tb_top;

    localparam int N = 32;

    typedef struct packed {
        logic [N-1:0] bits;
        logic         bp;
        logic [N-1:0] exp;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{32'h0000_0000, 1'b0, 32'h0000_0000},
        '{32'h0000_0000, 1'b1, 32'hFFFF_FFFF},
        '{32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFF},
        '{32'hFFFF_FFFF, 1'b1, 32'h0000_0000},
        '{32'hAAAA_AAAA, 1'b0, 32'hAAAA_AAAA},
        '{32'hAAAA_AAAA, 1'b1, 32'h5555_5555},
        '{32'h8000_0001, 1'b1, 32'h7FFF_FFFE},
        '{32'h3C5A_0FF0, 1'b1, 32'hC3A5_F00F},
        '{32'h3C5A_0FF0, 1'b0, 32'h3C5A_0FF0},
        '{32'h0001_0000, 1'b1, 32'hFFFE_FFFF}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         osc = 1'b0;
    logic         mode_drv = 1'b0;
    logic [N-1:0] seg_bits = '1;
    logic         bp;
    logic [N-1:0] seg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lcd_phase_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_i      (osc),
        .mode_drv_i (mode_drv),
        .seg_bits_i (seg_bits),
        .bp_o       (bp),
        .seg_o      (seg)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic osc_pulse();
        osc = 1'b1;
        wait_neg(6);
        osc = 1'b0;
        wait_neg(6);
    endtask

    task automatic seg_rule(input string tag);
        logic [N-1:0] exp;
        for (int i = 0; i < N; i++) begin
            exp[i] = seg_bits[i] ? ~bp : bp;
        end
        check(seg === exp, tag, seg, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with all segment bits set and the input toggling
        wait_neg(2);
        osc = 1'b1;
        wait_neg(3);
        check(bp === 1'b0, "R1 backplane low in reset", N'(bp), '0);
        check(seg === {N{1'b0}}, "R1 segments blank in reset", seg, '0);
        osc = 1'b0;
        wait_neg(3);
        seg_bits = '0;
        rst_n = 1'b1;
        wait_neg(3);

        // R2 and R3: oscillator mode division by 256
        begin
            int highs;
            highs = 0;
            for (int k = 1; k <= 512; k++) begin
                osc_pulse();
                if (k == 127 || k == 128 || k == 255 || k == 256 || k == 383 || k == 384)
                    check(bp === (((k % 256) >= 128) ? 1'b1 : 1'b0),
                          $sformatf("R2 backplane after %0d rising edges", k),
                          N'(bp), N'((k % 256) >= 128));
                if (k > 256 && bp === 1'b1) highs++;
            end
            check(highs == 128, "R3 duty over 256 rising edges", N'(highs), N'(128));
        end

        // R5: partial count, then driven mode, then back
        for (int k = 0; k < 60; k++) osc_pulse();
        check(bp === 1'b0, "R5 partial count keeps backplane low", N'(bp), '0);
        mode_drv = 1'b1;
        wait_neg(4);
        for (int k = 0; k < 3; k++) begin
            osc = 1'b1;
            wait_neg(6);
            check(bp === 1'b1, "R4 driven backplane follows high", N'(bp), N'(1));
            osc = 1'b0;
            wait_neg(6);
            check(bp === 1'b0, "R4 driven backplane follows low", N'(bp), '0);
        end
        mode_drv = 1'b0;
        wait_neg(4);
        for (int k = 0; k < 127; k++) osc_pulse();
        check(bp === 1'b0, "R5 count restarted, 127 edges low", N'(bp), '0);
        osc_pulse();
        check(bp === 1'b1, "R5 count restarted, 128 edges high", N'(bp), N'(1));

        // R4: exact latency in driven mode
        mode_drv = 1'b1;
        osc = 1'b0;
        wait_neg(6);
        osc = 1'b1;
        wait_neg(2);
        check(bp === 1'b0, "R4 unchanged after two edges", N'(bp), '0);
        wait_neg(1);
        check(bp === 1'b1, "R4 changed after three edges", N'(bp), N'(1));
        osc = 1'b0;
        wait_neg(2);
        check(bp === 1'b1, "R4 fall unchanged after two edges", N'(bp), N'(1));
        wait_neg(1);
        check(bp === 1'b0, "R4 fall after three edges", N'(bp), '0);

        // R6 and R7: table walk in driven mode
        foreach (VECS[v]) begin
            osc = VECS[v].bp;
            seg_bits = VECS[v].bits;
            wait_neg(4);
            check(bp === VECS[v].bp, $sformatf("R4 table row %0d backplane", v),
                  N'(bp), N'(VECS[v].bp));
            check(seg === VECS[v].exp, $sformatf("R6 R7 table row %0d segments", v),
                  seg, VECS[v].exp);
        end

        // R6 and R7: random patterns under both backplane levels
        for (int r = 0; r < 6; r++) begin
            osc = r[0];
            seg_bits = $urandom;
            wait_neg(4);
            seg_rule($sformatf("R6 R7 random pattern %0d", r));
        end

        // R8: change between edges, judged before the next edge
        osc = 1'b1;
        seg_bits = '0;
        wait_neg(4);
        #2;
        seg_bits = 32'h0F0F_00FF;
        #1;
        check(seg === ~32'h0F0F_00FF, "R8 same-cycle update bp high",
              seg, ~32'h0F0F_00FF);
        osc = 1'b0;
        wait_neg(4);
        #2;
        seg_bits = 32'h1234_8001;
        #1;
        check(seg === 32'h1234_8001, "R8 same-cycle update bp low",
              seg, 32'h1234_8001);

        // R6 and R7 in oscillator mode while the backplane is high
        mode_drv = 1'b0;
        wait_neg(4);
        for (int k = 0; k < 128; k++) osc_pulse();
        check(bp === 1'b1, "R2 backplane high before segment check", N'(bp), N'(1));
        seg_rule("R6 R7 oscillator mode high phase");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule